// File: doc/BRIEF.md
# I2C Command-Coded Configuration Register Target

This block is an I2C target that holds a bank of eight 8-bit configuration registers and presents all of them as one parallel output vector. A controller reaches the bank through byte and block transfers. The first byte after the address is a command byte. It chooses single-byte or block access, carries a two-bit select field that must be zero, and for single-byte access gives the register offset. Block writes carry a byte count from the controller. Block reads start with a count sent by the target. Block transfers always start at register 0.

SCL and SDA are sampled on a fast system clock through two-flop synchronizers. The block detects START and STOP from SDA edges while SCL is high. It pulls SDA low through an output enable and never drives it high. Every register loads a known default at reset, so the bank can be used without any bus access.

Top module: `i2c_cfg_target`

## Requirements
- R1: The target acknowledges only the 7-bit address 7'h69 (byte D2h for write, D3h for read). For any other address it does not acknowledge, it does not acknowledge any later byte of that transaction, and it changes no register.
- R2: If command bits 6:5 are not 00, the command byte is not acknowledged, the following bytes are not acknowledged, and no register changes.
- R3: A command with bit 7 = 1 is a single-byte access to the register given by bits 4:0. The first data byte of a write is stored there. Further data bytes, and writes to offsets 8 and above, are acknowledged and discarded.
- R4: A single-byte read (command, repeated START, address D3h) returns the addressed register MSB first. An offset of 8 or above returns 8'h00.
- R5: A command with bit 7 = 0 is a block access. In a block write, the byte after the command is a count N. Up to N following bytes are stored in registers 0, 1, 2 and so on. Bytes beyond N or beyond register 7 are acknowledged and discarded.
- R6: A block read first returns the count 8'd8, then registers 0 upward, for as long as the controller acknowledges. A position past register 7 returns 8'h00.
- R7: After reset, register i holds 8'hA0 + i. A register changes only when a complete data byte has been received. A transfer cut short by STOP in the middle of a byte changes nothing.
- R8: The target pulls SDA low only by raising `sda_oe`. It raises `sda_oe` only while SCL is low, and it has released SDA after reset and after a STOP.
- R9: A START or repeated START at any point releases SDA and restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, far faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| cfg_regs | output | NREG*8 | Register contents; register i sits at bits 8i+7:8i |

## Verification
A wrong protocol state shows up on the SDA line within one bit time: the acknowledge bit is missing or appears where it should not, or the read data shifts by one bit. Either way the controller sees it at the next SCL high. A wrong pointer or count corrupts `cfg_regs` or the read stream at the first byte it touches. Each scenario therefore compares every acknowledge bit and read byte, and compares the whole register vector with a model after each STOP.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_RXACK, ST_TX, ST_TXACK, ST_SKIP} tgt_state_t;
  typedef enum logic [1:0] {PH_ADDR, PH_CMD, PH_DATA} rx_phase_t;

  function automatic logic [BYTE_W-1:0] reg_default(input int idx);
    return BYTE_W'(8'hA0 + idx);
  endfunction
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_now,
  output logic sda_now,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_now   = scl_ff[STAGES-1];
  assign sda_now   = sda_ff[STAGES-1];
  assign scl_rise  = scl_now & ~scl_d;
  assign scl_fall  = ~scl_now & scl_d;
  assign start_det = scl_now & scl_d & sda_d & ~sda_now;
  assign stop_det  = scl_now & scl_d & ~sda_d & sda_now;
endmodule

// File: rtl/i2c_cfg_regbank.sv
module i2c_cfg_regbank
  import i2c_cfg_pkg::*;
#(
  parameter int NREG = 8,
  localparam int AW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic [NREG*BYTE_W-1:0] regs_flat
);
  logic [BYTE_W-1:0] bank [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        bank[i] <= reg_default(i);
      else if (wr_en && wr_addr == AW'(i))
        bank[i] <= wr_data;
    end
    assign regs_flat[i*BYTE_W +: BYTE_W] = bank[i];
  end

  assign rd_data = bank[rd_addr];
endmodule

// File: rtl/i2c_cfg_engine.sv
module i2c_cfg_engine
  import i2c_cfg_pkg::*;
#(
  parameter int NREG = 8,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int PW = 6,
  localparam int AW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_now,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [AW-1:0]     rd_addr,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe
);
  tgt_state_t st;
  rx_phase_t  ph;
  logic [2:0] bitcnt;
  logic [BYTE_W-1:0] shreg, tx_sh, remain;
  logic byte_full, go_tx, block_mode, need_cnt, send_cnt, mst_ack;
  logic [PW-1:0] ptr;
  logic in_range;
  logic [BYTE_W-1:0] tx_next;

  assign in_range = ptr < PW'(NREG);
  assign rd_addr  = ptr[AW-1:0];
  assign tx_next  = send_cnt ? BYTE_W'(NREG) : (in_range ? rd_data : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; ph <= PH_ADDR; bitcnt <= '0; shreg <= '0; tx_sh <= '0;
      remain <= '0; byte_full <= 1'b0; go_tx <= 1'b0; block_mode <= 1'b0;
      need_cnt <= 1'b0; send_cnt <= 1'b0; mst_ack <= 1'b0; ptr <= '0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0; sda_oe <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        st <= ST_RX; ph <= PH_ADDR; bitcnt <= '0; byte_full <= 1'b0; sda_oe <= 1'b0;
      end else if (stop_det) begin
        st <= ST_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_now};
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) byte_full <= 1'b1;
            end else if (scl_fall && byte_full) begin
              byte_full <= 1'b0;
              bitcnt    <= '0;
              case (ph)
                PH_ADDR: begin
                  if (shreg[7:1] == DEV_ADDR) begin
                    sda_oe <= 1'b1; st <= ST_RXACK; go_tx <= shreg[0]; ph <= PH_CMD;
                    if (shreg[0]) begin
                      send_cnt <= block_mode;
                      if (block_mode) ptr <= '0;
                    end
                  end else begin
                    st <= ST_SKIP;
                  end
                end
                PH_CMD: begin
                  if (shreg[6:5] != 2'b00) begin
                    st <= ST_SKIP;
                  end else begin
                    sda_oe <= 1'b1; st <= ST_RXACK; go_tx <= 1'b0; ph <= PH_DATA;
                    block_mode <= ~shreg[7];
                    need_cnt   <= ~shreg[7];
                    remain     <= BYTE_W'(1);
                    ptr        <= shreg[7] ? PW'(shreg[4:0]) : '0;
                  end
                end
                default: begin
                  sda_oe <= 1'b1; st <= ST_RXACK; go_tx <= 1'b0;
                  if (need_cnt) begin
                    remain   <= shreg;
                    need_cnt <= 1'b0;
                  end else if (remain != '0) begin
                    remain <= remain - BYTE_W'(1);
                    if (in_range) begin
                      wr_en   <= 1'b1;
                      wr_addr <= ptr[AW-1:0];
                      wr_data <= shreg;
                    end
                    if (ptr != '1) ptr <= ptr + PW'(1);
                  end
                end
              endcase
            end
          end
          ST_RXACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (go_tx) begin
                tx_sh  <= tx_next;
                sda_oe <= ~tx_next[7];
                st     <= ST_TX;
                if (!send_cnt && ptr != '1) ptr <= ptr + PW'(1);
                send_cnt <= 1'b0;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 3'd7) begin
                sda_oe <= 1'b0;
                st     <= ST_TXACK;
              end else begin
                bitcnt <= bitcnt + 3'd1;
                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                sda_oe <= ~tx_sh[6];
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              mst_ack <= ~sda_now;
            end else if (scl_fall) begin
              if (mst_ack && block_mode) begin
                bitcnt <= '0;
                tx_sh  <= tx_next;
                sda_oe <= ~tx_next[7];
                st     <= ST_TX;
                if (!send_cnt && ptr != '1) ptr <= ptr + PW'(1);
                send_cnt <= 1'b0;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
  import i2c_cfg_pkg::*;
#(
  parameter int NREG = 8,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(NREG)
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  output logic [NREG*BYTE_W-1:0] cfg_regs
);
  logic scl_now, sda_now, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [BYTE_W-1:0] wr_data, rd_data;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_now(scl_now), .sda_now(sda_now), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_cfg_engine #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_engine (
    .clk(clk), .rst(rst), .sda_now(sda_now), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe)
  );

  i2c_cfg_regbank #(.NREG(NREG)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .regs_flat(cfg_regs)
  );
endmodule

// File: rtl/i2c_cfg_target_chk.sv
module i2c_cfg_target_chk #(
  parameter int NREG = 8,
  localparam int AW = $clog2(NREG)
) (
  input logic clk,
  input logic rst,
  input logic sda_oe,
  input logic scl_now,
  input logic start_det,
  input logic stop_det,
  input logic wr_en,
  input logic [NREG*8-1:0] cfg_regs
);
  AST_RST_RELEASE:   assert property (@(posedge clk) rst |=> !sda_oe); // R8
  AST_STOP_RELEASE:  assert property (@(posedge clk) disable iff (rst) stop_det |=> !sda_oe); // R8
  AST_START_RELEASE: assert property (@(posedge clk) disable iff (rst) start_det |=> !sda_oe); // R9
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst) $rose(sda_oe) |-> !scl_now); // R8
  AST_REG_HOLD:      assert property (@(posedge clk) disable iff (rst) !wr_en |=> $stable(cfg_regs)); // R7
  AST_WRITE_SCL_LOW: assert property (@(posedge clk) disable iff (rst) wr_en |-> !scl_now); // R3
endmodule

bind i2c_cfg_target i2c_cfg_target_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .scl_now(scl_now), .start_det(start_det),
  .stop_det(stop_det), .wr_en(wr_en), .cfg_regs(cfg_regs)
);

// File: tb/i2c_cfg_target_bench.sv
module i2c_cfg_target_bench;
  localparam int NREG = 8;
  localparam int Q = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe;
  logic [NREG*8-1:0] cfg_regs;
  logic sda_line;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] mdl [NREG];

  always #5 clk = ~clk;
  assign sda_line = ~(m_low | sda_oe);

  i2c_cfg_target u_i2c_cfg_target (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .cfg_regs(cfg_regs)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_regs(input string tag);
    for (int i = 0; i < NREG; i++) chk(tag, cfg_regs[i*8 +: 8], mdl[i]);
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b1; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_rstart();
    m_low = 1'b0; wq(); m_scl = 1'b1; wq(); m_low = 1'b1; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wq(); m_scl = 1'b1; wq(); m_low = 1'b0; wq(); wq();
  endtask

  task automatic send_bit(input logic b);
    m_low = ~b; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
  endtask

  task automatic recv_bit(output logic b);
    m_low = 1'b0; wq(); m_scl = 1'b1; wq(); b = sda_line; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic wr_byte(input logic [7:0] v, input logic exp_ack, input string tag);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(a);
    chk(tag, {7'd0, ~a}, {7'd0, exp_ack});
  endtask

  task automatic rd_byte(input logic give_ack, input logic [7:0] exp, input string tag);
    logic [7:0] d;
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~give_ack);
    chk(tag, d, exp);
  endtask

  task automatic t_reset();
    for (int i = 0; i < NREG; i++) mdl[i] = 8'hA0 + 8'(i);
    chk_regs("R7 reset defaults");
    chk("R8 released after reset", {7'd0, sda_oe}, 8'd0);
  endtask

  task automatic t_byte_write();
    bus_start();
    wr_byte(8'hD2, 1'b1, "R1 address ack");
    wr_byte(8'h83, 1'b1, "R3 command ack");
    wr_byte(8'h5A, 1'b1, "R3 data ack");
    bus_stop();
    mdl[3] = 8'h5A;
    chk_regs("R3 byte write offset 3");
    chk("R8 released after stop", {7'd0, sda_oe}, 8'd0);
  endtask

  task automatic t_byte_read(input logic [4:0] off, input logic [7:0] exp);
    bus_start();
    wr_byte(8'hD2, 1'b1, "R4 address ack");
    wr_byte({3'b100, off}, 1'b1, "R4 command ack");
    bus_rstart();
    wr_byte(8'hD3, 1'b1, "R9 read address ack after repeated start");
    rd_byte(1'b0, exp, "R4 byte read data");
    bus_stop();
  endtask

  task automatic t_wrong_addr();
    bus_start();
    wr_byte(8'h44, 1'b0, "R1 foreign address nack");
    wr_byte(8'h83, 1'b0, "R1 later byte nack");
    wr_byte(8'hEE, 1'b0, "R1 data nack");
    bus_stop();
    chk_regs("R1 no change on foreign address");
  endtask

  task automatic t_chip_select();
    bus_start();
    wr_byte(8'hD2, 1'b1, "R2 address ack");
    wr_byte(8'hA4, 1'b0, "R2 select field nonzero nack");
    wr_byte(8'h99, 1'b0, "R2 data nack");
    bus_stop();
    chk_regs("R2 no change on select mismatch");
  endtask

  task automatic t_block_write(input int cnt, input int nbytes, input logic [7:0] base);
    bus_start();
    wr_byte(8'hD2, 1'b1, "R5 address ack");
    wr_byte(8'h00, 1'b1, "R5 block command ack");
    wr_byte(8'(cnt), 1'b1, "R5 count ack");
    for (int i = 0; i < nbytes; i++) begin
      wr_byte(base + 8'(i), 1'b1, "R5 block data ack");
      if (i < cnt && i < NREG) mdl[i] = base + 8'(i);
    end
    bus_stop();
    chk_regs("R5 block write contents");
  endtask

  task automatic t_block_read();
    bus_start();
    wr_byte(8'hD2, 1'b1, "R6 address ack");
    wr_byte(8'h00, 1'b1, "R6 block command ack");
    bus_rstart();
    wr_byte(8'hD3, 1'b1, "R6 read address ack");
    rd_byte(1'b1, 8'd8, "R6 count byte");
    for (int i = 0; i < NREG; i++) rd_byte(1'b1, mdl[i], "R6 block data");
    rd_byte(1'b0, 8'h00, "R6 past last register");
    bus_stop();
  endtask

  task automatic t_out_of_range_write();
    bus_start();
    wr_byte(8'hD2, 1'b1, "R3 address ack");
    wr_byte(8'h89, 1'b1, "R3 offset 9 command ack");
    wr_byte(8'h3C, 1'b1, "R3 offset 9 data ack");
    bus_stop();
    chk_regs("R3 offset 9 discarded");
  endtask

  task automatic t_extra_bytes();
    bus_start();
    wr_byte(8'hD2, 1'b1, "R3 address ack");
    wr_byte(8'h81, 1'b1, "R3 command ack");
    wr_byte(8'h77, 1'b1, "R3 first data ack");
    wr_byte(8'h88, 1'b1, "R3 extra data ack");
    bus_stop();
    mdl[1] = 8'h77;
    chk_regs("R3 only first data byte stored");
  endtask

  task automatic t_partial_byte();
    bus_start();
    wr_byte(8'hD2, 1'b1, "R7 address ack");
    wr_byte(8'h85, 1'b1, "R7 command ack");
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    chk_regs("R7 partial byte discarded");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_byte_write();
    t_byte_read(5'd3, 8'h5A);
    t_byte_read(5'd6, 8'hA6);
    t_wrong_addr();
    t_chip_select();
    t_block_write(3, 4, 8'h11);
    t_block_write(10, 10, 8'h40);
    t_block_read();
    t_out_of_range_write();
    t_byte_read(5'd12, 8'h00);
    t_extra_bytes();
    t_partial_byte();
    t_byte_read(5'd1, 8'h77);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule